// File: doc/BRIEF.md
# Threshold-Paced Transmit Audio Buffer

This block sits on the transmit path between the memory side and a serial audio shifter. Words arrive on a write port and are stored in order. The shifter pulls them back out one at a time. A DMA request tells the memory side when to refill the buffer. The block also reports how many words it holds, so software can work out the playback delay: the fill level divided by the channel count, with any partial sample dropped.

The request follows one of two pacing modes. In per-element mode the block asks for data as soon as one word slot is free. In threshold mode it waits until the free space reaches a programmed word count. Software programs that count minus one, and normally uses half the transfer block size in bytes. In both modes the request is not released at the threshold. It stays asserted until the buffer is completely full. This keeps the refill in large bursts and avoids starving the shifter at start-up.

A read from an empty buffer returns zero and sets a sticky underflow flag. A write to a full buffer is dropped and sets a sticky overflow flag. Clearing the enable flushes the buffer, clears both flags and holds the request low.

Top module: `audio_tx_fifo_dreq`

## Requirements
- R1: After reset, `fill` is 0, `dma_req` is 0, both flags are 0 and `rd_data` is 0.
- R2: While enabled, a write (`wr_valid`=1) to a buffer that is not full is stored. A read (`rd_req`=1) on a buffer that is not empty returns words in write order on `rd_data` from the clock edge that accepts the read. `rd_data` holds its value otherwise.
- R3: `fill` rises by one for each accepted write and falls by one for each accepted read, both counted at the same edge. A write and a read accepted together leave it unchanged. It never exceeds DEPTH (default 1024).
- R4: With `mode_thr`=0 (per-element), the target is 1 word and `thr_m1` is ignored. The request is raised at the edge after at least one slot is free.
- R5: With `mode_thr`=1 (threshold), the target is `thr_m1`+1 words. While the request is low, it is raised at the edge after the one where the free space (DEPTH - `fill`) becomes at least the target. It stays low while the free space is below the target.
- R6: Once raised, `dma_req` stays high in both modes until `fill` reaches DEPTH. It falls at the next edge after that.
- R7: A read with `fill`=0 sets `rd_data` to 0 at that edge, leaves `fill` unchanged and sets `underflow`, which stays set while the block is enabled. A write and an underflowing read that arrive together still store the write.
- R8: A write with `fill`=DEPTH is dropped, even if a read arrives in the same cycle. It leaves the stored words unchanged and sets `overflow`, which stays set while the block is enabled.
- R9: An edge with `en`=0 empties the buffer (`fill`=0), clears both flags, clears `rd_data` and drives `dma_req` low. Writes and reads at such an edge have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low flushes |
| mode_thr | input | 1 | 0 = per-element pacing, 1 = threshold pacing |
| thr_m1 | input | 10 | Target word count minus one (threshold mode) |
| wr_valid | input | 1 | Write strobe from the memory side |
| wr_data | input | 32 | Write word |
| rd_req | input | 1 | Read strobe from the shifter |
| rd_data | output | 32 | Word returned for the last read |
| dma_req | output | 1 | Refill request |
| fill | output | 11 | Words currently held |
| underflow | output | 1 | Sticky: read attempted while empty |
| overflow | output | 1 | Sticky: write attempted while full |

## Verification
A miscounted fill level shows on `fill` at the edge that should have changed it. Within a few hundred cycles it also shows as a request that falls too early or too late relative to the full point. A pointer fault shows on `rd_data` at the first read that reaches the wrong slot. The bench places words with distinct values around the wrap point, so such a fault shows directly. A request-state fault shows one edge after the boundary fill level: exactly full, or free space equal to the target and to the target minus one. So the bench samples `dma_req` on both sides of each boundary.

// File: rtl/atf_pkg.sv
package atf_pkg;

  // Words the free space must reach before a refill request is raised.
  function automatic int target_words(input logic mode_thr, input int thr_m1);
    return mode_thr ? (thr_m1 + 1) : 1;
  endfunction

  // Free slots for a given fill level.
  function automatic int free_words(input int depth, input int fill_lvl);
    return depth - fill_lvl;
  endfunction

endpackage

// File: rtl/atf_storage.sv
module atf_storage #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ok,
  input  logic              rd_empty,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_data <= '0;
    end else if (flush) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_ok) wptr <= bump(wptr);
      if (rd_ok) begin
        rptr    <= bump(rptr);
        rd_data <= mem[rptr];
      end else if (rd_empty) begin
        rd_data <= '0;
      end
    end
  end

  // R7
  zero_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && rd_empty) |=> (rd_data == '0));

  // R2
  hold_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !rd_ok && !rd_empty) |=> $stable(rd_data));

endmodule

// File: rtl/atf_level.sv
module atf_level #(
  parameter int DEPTH = 1024,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_valid,
  input  logic          rd_req,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          rd_empty,
  output logic [CW-1:0] fill,
  output logic          underflow,
  output logic          overflow
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic is_full, is_empty, wr_drop;

  assign is_full  = (fill == FULL_LVL);
  assign is_empty = (fill == '0);
  assign wr_ok    = en && wr_valid && !is_full;
  assign rd_ok    = en && rd_req && !is_empty;
  assign rd_empty = en && rd_req && is_empty;
  assign wr_drop  = en && wr_valid && is_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill      <= '0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else if (!en) begin
      fill      <= '0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      case ({wr_ok, rd_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (rd_empty) underflow <= 1'b1;
      if (wr_drop)  overflow  <= 1'b1;
    end
  end

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_LVL);

  // R3
  fill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr_valid && !rd_req) |=> $stable(fill));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (overflow || wr_drop)) |=> overflow);

  // R7
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (underflow || rd_empty)) |=> underflow);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && is_full && wr_valid && !rd_req) |=> (fill == FULL_LVL));

endmodule

// File: rtl/atf_dreq.sv
module atf_dreq
  import atf_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mode_thr,
  input  logic [AW-1:0] thr_m1,
  input  logic [CW-1:0] fill,
  output logic          dma_req
);

  logic buf_full, room_ok;
  int   want, room;

  assign want     = target_words(mode_thr, int'(thr_m1));
  assign room     = free_words(DEPTH, int'(fill));
  assign room_ok  = (room >= want);
  assign buf_full = (int'(fill) == DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dma_req <= 1'b0;
    else if (!en)     dma_req <= 1'b0;
    else if (dma_req) dma_req <= !buf_full;
    else              dma_req <= room_ok;
  end

  // R6
  dreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dma_req && !buf_full) |=> dma_req);

  // R6
  dreq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |=> !dma_req);

  // R5
  dreq_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && !room_ok) |=> !dma_req);

  // R9
  dreq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !dma_req);

endmodule

// File: rtl/audio_tx_fifo_dreq.sv
module audio_tx_fifo_dreq #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mode_thr,
  input  logic [AW-1:0]     thr_m1,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              dma_req,
  output logic [CW-1:0]     fill,
  output logic              underflow,
  output logic              overflow
);

  logic wr_ok, rd_ok, rd_empty, flush;

  assign flush = !en;

  atf_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wr_valid(wr_valid), .rd_req(rd_req),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .rd_empty(rd_empty),
    .fill(fill), .underflow(underflow), .overflow(overflow)
  );

  atf_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_ok(wr_ok), .wr_data(wr_data),
    .rd_ok(rd_ok), .rd_empty(rd_empty), .rd_data(rd_data)
  );

  atf_dreq #(.DEPTH(DEPTH)) u_dreq (
    .clk(clk), .rst_n(rst_n), .en(en),
    .mode_thr(mode_thr), .thr_m1(thr_m1),
    .fill(fill), .dma_req(dma_req)
  );

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fill == '0 && !underflow && !overflow && rd_data == '0));

endmodule

// File: tb/audio_tx_fifo_dreq_test.sv
module audio_tx_fifo_dreq_test;

  localparam int CLK_P = 10;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        mode_thr = 1'b0;
  logic [9:0]  thr_m1 = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_data;
  logic        dma_req;
  logic [10:0] fill;
  logic        underflow, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  audio_tx_fifo_dreq uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_thr(mode_thr), .thr_m1(thr_m1),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
    .dma_req(dma_req), .fill(fill), .underflow(underflow), .overflow(overflow)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic        rd;
    logic [10:0] fill;
    logic [31:0] rdat;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 32'hA1, 1'b0, 11'd1, 32'h0},
    '{1'b1, 32'hA2, 1'b0, 11'd2, 32'h0},
    '{1'b1, 32'hA3, 1'b1, 11'd2, 32'hA1},
    '{1'b0, 32'h0,  1'b1, 11'd1, 32'hA2},
    '{1'b1, 32'hA4, 1'b1, 11'd1, 32'hA3},
    '{1'b0, 32'h0,  1'b1, 11'd0, 32'hA4},
    '{1'b0, 32'h0,  1'b1, 11'd0, 32'h0},
    '{1'b1, 32'hA5, 1'b1, 11'd1, 32'h0}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic cyc(input logic w, input logic [31:0] d, input logic r);
    wr_valid = w; wr_data = d; rd_req = r;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; rd_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fill at reset", 32'(fill), 0);
    chk("R1 dma_req at reset", 32'(dma_req), 0);
    chk("R1 flags at reset", {30'b0, underflow, overflow}, 0);
    chk("R1 rd_data at reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Enable in per-element mode with a nonzero threshold field (ignored).
    en = 1'b1; thr_m1 = 10'd5;
    cyc(0, 0, 0);
    chk("R4 request raised on empty", 32'(dma_req), 1);

    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i].wr, VEC[i].wd, VEC[i].rd);
      chk($sformatf("R3 table fill step %0d", i), 32'(fill), 32'(VEC[i].fill));
      chk($sformatf("R2 table rd_data step %0d", i), rd_data, VEC[i].rdat);
    end
    chk("R7 underflow sticky", 32'(underflow), 1);
    chk("R7 no false overflow", 32'(overflow), 0);

    // Disable with a write and a read pending: both ignored, everything flushed.
    en = 1'b0;
    cyc(1, 32'h77, 1);
    chk("R9 fill flushed", 32'(fill), 0);
    chk("R9 request low", 32'(dma_req), 0);
    chk("R9 flags cleared", {30'b0, underflow, overflow}, 0);
    chk("R9 rd_data cleared", rd_data, 0);
    cyc(0, 0, 0);
    chk("R9 write ignored while off", 32'(fill), 0);

    en = 1'b1;
    cyc(0, 0, 0);
    chk("R4 request after re-enable", 32'(dma_req), 1);

    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 32'h100 + 32'(i), 0);
      if (i == 511) chk("R6 request held mid-fill", 32'(dma_req), 1);
    end
    chk("R3 fill at full", 32'(fill), DEPTH);
    chk("R6 request still high at full edge", 32'(dma_req), 1);
    cyc(0, 0, 0);
    chk("R6 request dropped after full", 32'(dma_req), 0);

    cyc(1, 32'hDEAD, 0);
    chk("R8 fill unchanged on overflow", 32'(fill), DEPTH);
    chk("R8 overflow set", 32'(overflow), 1);

    cyc(1, 32'hBEEF, 1);
    chk("R8 write dropped with read when full", 32'(fill), DEPTH - 1);
    chk("R8 first word intact", rd_data, 32'h100);
    chk("R8 overflow sticky", 32'(overflow), 1);
    chk("R4 no request on the edge that freed a slot", 32'(dma_req), 0);
    cyc(0, 0, 0);
    chk("R4 request with one slot free", 32'(dma_req), 1);

    // Threshold mode, target 4 words.
    mode_thr = 1'b1; thr_m1 = 10'd3;
    cyc(1, 32'h500, 0);
    chk("R6 held until full (threshold)", 32'(dma_req), 1);
    cyc(0, 0, 0);
    chk("R6 dropped at full (threshold)", 32'(dma_req), 0);

    cyc(0, 0, 1);
    chk("R2 order word 2", rd_data, 32'h101);
    cyc(0, 0, 1);
    cyc(0, 0, 1);
    chk("R2 order word 4", rd_data, 32'h103);
    cyc(0, 0, 0);
    chk("R5 no request at free = target-1", 32'(dma_req), 0);
    cyc(0, 0, 1);
    chk("R5 no request yet at free = target edge", 32'(dma_req), 0);
    cyc(0, 0, 0);
    chk("R5 request at free = target", 32'(dma_req), 1);
    cyc(1, 32'h600, 0);
    chk("R3 fill after refill word", 32'(fill), DEPTH - 3);
    cyc(0, 0, 0);
    chk("R6 request held below target", 32'(dma_req), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule